// File: doc/BRIEF.md
# Bidirectional Port Controller with Pin Overrides

This block controls an 8-pin general-purpose port. Software sees three registers: a direction register, an output latch, and a pin view. The pin view shows the pad levels after they pass through a two-flop synchronizer. For each pin the block produces an output value and an output enable, and the pad ring turns these into a tri-state driver. The direction register sets each pin separately as an input or an output.

Three peripheral inputs can take a pin away from ordinary I/O:

- An external-memory address bus drives the four low pins while its enable is active.
- An alternate PWM mapping places two PWM channels on pins 4 and 5.
- A 4-bit analog-select field turns any of the upper four pins into analog inputs. An analog pin has no digital driver, and its digital reading is forced to 0.

The rest of the chip supplies these controls as plain input signals.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the direction register reads 8'hFF, the latch reads 8'h00, and every pad output enable is 0.
- R2: A direction bit of 0 enables that pin's driver and puts its latch bit on the pad. A direction bit of 1 disables the driver. For example, writing 8'hCF makes pins 5:4 outputs and all other pins inputs.
- R3: Reading the latch register (address 1) returns the value last written to the latch, whatever the pad levels are.
- R4: Reading the pin-view register (address 0) returns the synchronized pad levels. Writing address 0 updates the output latch.
- R5: A change on a pad input first appears in the pin view after the second rising clock edge that samples it. After only one edge the pin view still shows the old value.
- R6: While the memory-address enable is 1, pins 3:0 are driven with the 4-bit address (pin 0 carries bit 0), whatever their direction bits are.
- R7: While the PWM mapping control is 0, pin 4 carries channel B and pin 5 carries channel C, both driven, taking priority over direction and latch.
- R8: Upper pin 4+i (i = 0..3) is digital only when the analog field value is at least 12+i; otherwise it is analog. The value 4'hF makes all four pins digital. An analog pin has its output enable at 0 and reads 0 in the pin view.
- R9: On pins 4 and 5, analog mode takes priority over the alternate PWM mapping and keeps the driver off.
- R10: Writes to address 3 change no register, and reading address 3 returns 8'h00. Direction is register address 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 pin view, 1 latch, 2 direction, 3 reserved |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| pin_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables (1 = driven) |
| emi_en | input | 1 | Memory-address override enable |
| emi_addr | input | 4 | High-order memory address bits for pins 3:0 |
| pwm_map_n | input | 1 | 0 places the PWM channels on pins 4 and 5 |
| pwm_b | input | 1 | PWM channel B value |
| pwm_c | input | 1 | PWM channel C value |
| ana_cfg | input | 4 | Analog-select field for pins 7:4 |

## Verification
The bench checks the synchronizer latency edge by edge. A design with one stage too few would show the new level after the first edge, and one with a stage too many would still show the old level after the second. It runs the analog field through each decode boundary (F, E, D, C, B, 0), where an off-by-one threshold would leave one upper pin driven or still readable. It holds the PWM mapping against analog mode and against the direction bits, which exposes a design that orders the overrides wrongly by a wrong pad enable. It also writes the reserved address and writes through the pin-view address, so a decoder that aliases addresses shows up as a corrupted latch or direction value.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    ADDR_PINS  = 2'd0,
    ADDR_LATCH = 2'd1,
    ADDR_DIR   = 2'd2,
    ADDR_RSVD  = 2'd3
  } reg_addr_e;

  localparam int ANA_W = 4;

  // Bit i set: upper pin i is analog. Pin i is digital when cfg >= 12+i.
  function automatic logic [ANA_W-1:0] analog_mask(input logic [ANA_W-1:0] cfg);
    logic [ANA_W-1:0] m;
    for (int i = 0; i < ANA_W; i++) begin
      m[i] = ({1'b0, cfg} < 5'(12 + i));
    end
    return m;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  reg_addr_e    addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] dir_q
);
  logic lat_we, dir_we;

  assign lat_we = wr && (addr == ADDR_PINS || addr == ADDR_LATCH);
  assign dir_we = wr && (addr == ADDR_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
    end else begin
      if (lat_we) lat_q <= wdata;
      if (dir_we) dir_q <= wdata;
    end
  end

  // R10
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == ADDR_DIR) |=> $stable(dir_q));

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (addr == ADDR_PINS || addr == ADDR_LATCH)) |=> $stable(lat_q));
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int W      = 8,
  parameter int EMI_LO = 0,
  parameter int EMI_N  = 4,
  parameter int PWM_LO = 4,
  parameter int ANA_LO = 4,
  parameter int ANA_N  = 4
) (
  input  logic [W-1:0]     lat,
  input  logic [W-1:0]     dir,
  input  logic             emi_en,
  input  logic [EMI_N-1:0] emi_addr,
  input  logic             pwm_alt,
  input  logic             pwm_b,
  input  logic             pwm_c,
  input  logic [ANA_N-1:0] ana_mask,
  output logic [W-1:0]     pad_out,
  output logic [W-1:0]     pad_oe
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    logic ana_on, emi_on, emi_bit, pwm_on, pwm_bit;

    if (p >= EMI_LO && p < EMI_LO + EMI_N) begin : g_emi
      assign emi_on  = emi_en;
      assign emi_bit = emi_addr[p-EMI_LO];
    end else begin : g_no_emi
      assign emi_on  = 1'b0;
      assign emi_bit = 1'b0;
    end

    if (p == PWM_LO) begin : g_pwm_b
      assign pwm_on  = pwm_alt;
      assign pwm_bit = pwm_b;
    end else if (p == PWM_LO + 1) begin : g_pwm_c
      assign pwm_on  = pwm_alt;
      assign pwm_bit = pwm_c;
    end else begin : g_no_pwm
      assign pwm_on  = 1'b0;
      assign pwm_bit = 1'b0;
    end

    if (p >= ANA_LO && p < ANA_LO + ANA_N) begin : g_ana
      assign ana_on = ana_mask[p-ANA_LO];
    end else begin : g_no_ana
      assign ana_on = 1'b0;
    end

    always_comb begin
      if (ana_on) begin
        pad_oe[p]  = 1'b0;
        pad_out[p] = 1'b0;
      end else if (emi_on) begin
        pad_oe[p]  = 1'b1;
        pad_out[p] = emi_bit;
      end else if (pwm_on) begin
        pad_oe[p]  = 1'b1;
        pad_out[p] = pwm_bit;
      end else begin
        pad_oe[p]  = ~dir[p];
        pad_out[p] = lat[p];
      end
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter int EMI_LO      = 0,
  parameter int EMI_N       = 4,
  parameter int PWM_LO      = 4,
  parameter int ANA_LO      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     pad_out,
  output logic [W-1:0]     pad_oe,
  input  logic             emi_en,
  input  logic [EMI_N-1:0] emi_addr,
  input  logic             pwm_map_n,
  input  logic             pwm_b,
  input  logic             pwm_c,
  input  logic [ANA_W-1:0] ana_cfg
);
  reg_addr_e        addr_e;
  logic [W-1:0]     lat_q, dir_q, pins_sync, ana_vec, pin_view;
  logic [ANA_W-1:0] ana_mask;
  logic             pwm_alt;

  assign addr_e   = reg_addr_e'(reg_addr);
  assign ana_mask = analog_mask(ana_cfg);
  assign ana_vec  = W'(ana_mask) << ANA_LO;
  assign pwm_alt  = ~pwm_map_n;
  assign pin_view = pins_sync & ~ana_vec;

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(addr_e),
    .wdata(reg_wdata), .lat_q(lat_q), .dir_q(dir_q)
  );

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_sync)
  );

  gpio_pinmux #(
    .W(W), .EMI_LO(EMI_LO), .EMI_N(EMI_N), .PWM_LO(PWM_LO),
    .ANA_LO(ANA_LO), .ANA_N(ANA_W)
  ) u_mux (
    .lat(lat_q), .dir(dir_q), .emi_en(emi_en), .emi_addr(emi_addr),
    .pwm_alt(pwm_alt), .pwm_b(pwm_b), .pwm_c(pwm_c), .ana_mask(ana_mask),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always_comb begin
    case (addr_e)
      ADDR_PINS:  reg_rdata = pin_view;
      ADDR_LATCH: reg_rdata = lat_q;
      ADDR_DIR:   reg_rdata = dir_q;
      default:    reg_rdata = '0;
    endcase
  end

  // R8
  ana_drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ana_vec) == '0);

  // R6
  emi_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emi_en |-> (pad_oe[EMI_LO +: EMI_N] == '1) && (pad_out[EMI_LO +: EMI_N] == emi_addr));

  // R7
  pwm_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_map_n && !ana_vec[PWM_LO]) |-> pad_oe[PWM_LO] && (pad_out[PWM_LO] == pwm_b));
endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata, reg_rdata, pin_in, pad_out, pad_oe;
  logic       emi_en, pwm_map_n, pwm_b, pwm_c;
  logic [3:0] emi_addr, ana_cfg;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .emi_en(emi_en), .emi_addr(emi_addr),
    .pwm_map_n(pwm_map_n), .pwm_b(pwm_b), .pwm_c(pwm_c), .ana_cfg(ana_cfg)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic t_reset();
    rd_chk("R1 dir", 2'd2, 8'hFF);
    rd_chk("R1 latch", 2'd1, 8'h00);
    check("R1 oe", pad_oe, 8'h00);
  endtask

  task automatic t_direction();
    ana_cfg = 4'hF;
    wr_reg(2'd1, 8'hA5);
    wr_reg(2'd2, 8'hCF);
    rd_chk("R2 dir read", 2'd2, 8'hCF);
    check("R2 oe", pad_oe, 8'h30);
    check("R2 out", pad_out & 8'h30, 8'h20);
    wr_reg(2'd2, 8'h00);
    check("R2 all out", pad_out, 8'hA5);
  endtask

  task automatic t_latch_pins();
    wr_reg(2'd1, 8'h3C);
    @(negedge clk); pin_in = 8'hC3;
    rd_chk("R3 latch vs pins", 2'd1, 8'h3C);
    repeat (2) @(negedge clk);
    rd_chk("R4 pin view", 2'd0, 8'hC3);
    wr_reg(2'd0, 8'h5A);
    rd_chk("R4 write via pins", 2'd1, 8'h5A);
  endtask

  task automatic t_sync();
    @(negedge clk); reg_addr = 2'd0; pin_in = 8'h0F;
    @(negedge clk); #1;
    check("R5 after one edge", reg_rdata, 8'hC3);
    @(negedge clk); #1;
    check("R5 after two edges", reg_rdata, 8'h0F);
  endtask

  task automatic t_emi();
    wr_reg(2'd2, 8'hFF);
    wr_reg(2'd1, 8'h0A);
    @(negedge clk); emi_en = 1'b1; emi_addr = 4'h5;
    #1;
    check("R6 oe", pad_oe, 8'h0F);
    check("R6 out", pad_out & 8'h0F, 8'h05);
    @(negedge clk); emi_en = 1'b0;
    #1;
    check("R6 release", pad_oe, 8'h00);
  endtask

  task automatic t_pwm();
    @(negedge clk); pwm_map_n = 1'b0; pwm_b = 1'b1; pwm_c = 1'b0;
    #1;
    check("R7 oe", pad_oe, 8'h30);
    check("R7 out b", pad_out & 8'h30, 8'h10);
    @(negedge clk); pwm_b = 1'b0; pwm_c = 1'b1;
    #1;
    check("R7 out c", pad_out & 8'h30, 8'h20);
    @(negedge clk); pwm_map_n = 1'b1;
    #1;
    check("R7 home", pad_oe, 8'h00);
  endtask

  task automatic t_analog();
    logic [3:0] cfgs [6] = '{4'hF, 4'hE, 4'hD, 4'hC, 4'hB, 4'h0};
    wr_reg(2'd2, 8'h00);
    @(negedge clk); pin_in = 8'hFF;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      int nd;
      logic [7:0] expv;
      nd = (cfgs[k] >= 4'd12) ? int'(cfgs[k]) - 11 : 0;
      expv = 8'h0F | 8'(((1 << nd) - 1) << 4);
      @(negedge clk); ana_cfg = cfgs[k];
      rd_chk("R8 pin view", 2'd0, expv);
      check("R8 oe", pad_oe, expv);
    end
  endtask

  task automatic t_ana_pwm();
    @(negedge clk); ana_cfg = 4'h0; pwm_map_n = 1'b0; pwm_b = 1'b1; pwm_c = 1'b1;
    #1;
    check("R9 oe", pad_oe & 8'h30, 8'h00);
    @(negedge clk); ana_cfg = 4'hF;
    #1;
    check("R9 digital again", pad_oe & 8'h30, 8'h30);
    @(negedge clk); pwm_map_n = 1'b1;
  endtask

  task automatic t_reserved();
    wr_reg(2'd2, 8'h5C);
    wr_reg(2'd1, 8'h99);
    wr_reg(2'd3, 8'hFF);
    rd_chk("R10 read", 2'd3, 8'h00);
    rd_chk("R10 dir", 2'd2, 8'h5C);
    rd_chk("R10 latch", 2'd1, 8'h99);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = 8'h00;
    pin_in = 8'h00; emi_en = 1'b0; emi_addr = 4'h0; pwm_map_n = 1'b1;
    pwm_b = 1'b0; pwm_c = 1'b0; ana_cfg = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direction();
    t_latch_pins();
    t_sync();
    t_emi();
    t_pwm();
    t_analog();
    t_ana_pwm();
    t_reserved();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule